// File: doc/BRIEF.md
# Dual-Output Waveform Timer

This block is an 8-bit waveform timer. A programmable clock divider feeds an up counter or an up/down counter, and two output channels shape the count into square waves or pulse-width modulated signals. One compare value, the top value, fixes the length of the count cycle. A second compare value, the duty value, places the edges of the second channel. The block is meant to sit beside an audio or control path. There it yields a 50% square wave and a duty-controlled wave that share one time base.

Three count modes are offered. In clear-on-match mode the counter restarts after it reaches the top value. In ramp mode it counts from zero to the top value and wraps. In triangle mode it climbs to the top value and then falls back to zero. Both compare values are held in shadow registers. A new value is therefore used only from the next cycle boundary, and a write in the middle of a cycle never cuts a pulse short. A one-clock pulse marks each time the counter reaches the top value.

Top module: `wave_timer`

## Requirements
- R1: A synchronous reset clears the counter to zero, sets the count direction to up and drives wave_a_o, wave_b_o and top_hit_o low.
- R2: clk_sel_i picks the tick rate: code 1 ticks every clock, code 2 every 8, code 3 every 64, code 4 every 256 and code 5 every 1024. Codes 0, 6 and 7 stop the counter, so no top_hit_o pulse occurs and the outputs do not move.
- R3: With mode_i = 0 (clear-on-match), the counter runs from 0 to the top value T and restarts at 0. top_hit_o then pulses once every T+1 ticks.
- R4: Pin code 1 (toggle) inverts a pin at each match of its compare value. On channel A this gives a 50% wave. Its period is 2(T+1) ticks in modes 0 and 1 and 4T ticks in mode 2.
- R5: With mode_i = 1 (ramp) and pin code 2, wave_b_o has a period of T+1 ticks and is high for D+1 ticks, where D is the duty value. If D >= T it stays high.
- R6: In modes 1 and 2, pin code 3 drives the complement of the code 2 waveform.
- R7: With mode_i = 2 (triangle), the counter goes 0 up to T and back to 0, so one period is 2T ticks. Under pin code 2, wave_b_o clears on a duty match while counting up and sets on a duty match while counting down. It is high for 2D ticks per period.
- R8: In mode 2 with pin code 2, a duty value of 0 holds wave_b_o low and a duty value >= T holds it high.
- R9: In mode 0, pin code 2 clears the pin on a match and pin code 3 sets it.
- R10: Pin code 0 holds the pin low whatever the counter does.
- R11: A new top or duty value takes effect only at the top of the count (modes 0 and 1) or at zero (mode 2). The cycle in progress finishes with the old value.
- R12: top_hit_o is exactly one clock wide at every divider setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Count mode: 0 clear-on-match, 1 ramp, 2 triangle, 3 treated as 0 |
| clk_sel_i | input | 3 | Tick divider select |
| top_val_i | input | 8 | Top value T (shadowed) |
| cmp_val_i | input | 8 | Duty value D for channel B (shadowed) |
| a_pin_mode_i | input | 2 | Channel A pin code: 0 off, 1 toggle, 2 clear, 3 set/inverting |
| b_pin_mode_i | input | 2 | Channel B pin code: 0 off, 1 toggle, 2 clear, 3 set/inverting |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| top_hit_o | output | 1 | One-clock pulse when the count reaches T |

## Verification
The bench measures high time and period from edge to edge on both pins. It covers every divider code, both ramp and triangle PWM, and both polarities. An off-by-one in the count ends, or a triangle that dwells twice at its turning points, shows up as a wrong period.

The duty extremes are checked in both PWM modes. Here a missing saturation rule would give a stray one-tick glitch or a stuck-wrong level.

A mid-cycle write of the top value checks the shadow registers. Without them the first cycle after the write would be shortened.

The stopped divider codes are checked for silence. Pulses at a slow divider must be one clock wide, which catches a match flag that stays up for a whole tick.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

  typedef enum logic [1:0] {
    CNT_MATCH_CLR = 2'd0,
    CNT_RAMP      = 2'd1,
    CNT_TRIANGLE  = 2'd2,
    CNT_SPARE     = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_mode_e;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int unsigned SH_B = 3,
  parameter int unsigned SH_C = 6,
  parameter int unsigned SH_D = 8,
  parameter int unsigned SH_E = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int unsigned PRE_W = (SH_E > 0) ? SH_E : 1;
  localparam logic [PRE_W-1:0] PONE = 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             run;
  int unsigned      sh;

  // Map select code to a power-of-two divide; unused codes halt the tick.
  always_comb begin
    run = 1'b1;
    sh  = 0;
    unique case (sel)
      3'd1:    sh = 0;
      3'd2:    sh = SH_B;
      3'd3:    sh = SH_C;
      3'd4:    sh = SH_D;
      3'd5:    sh = SH_E;
      default: run = 1'b0;
    endcase
    lim = PRE_W'((32'd1 << sh) - 32'd1);
  end

  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PONE;
    end
  end

endmodule

// File: rtl/wt_count.sv
module wt_count
  import wave_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] top_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             up_q,
  output logic [CNT_W-1:0] top_act_q,
  output logic [CNT_W-1:0] cmp_act_q,
  output logic             hit_top,
  output logic             hit_cmp
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic tri_m;
  logic at_load;

  assign tri_m   = (mode == CNT_TRIANGLE);
  assign hit_top = tick && (cnt_q == top_act_q);
  assign hit_cmp = tick && (cnt_q == cmp_act_q);
  // Shadow update point: top of ramp, or bottom of triangle.
  assign at_load = tick && (tri_m ? (cnt_q == '0) : (cnt_q == top_act_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      top_act_q <= '0;
      cmp_act_q <= '0;
    end else if (at_load) begin
      top_act_q <= top_in;
      cmp_act_q <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      if (tri_m) begin
        if (top_act_q == '0) begin
          cnt_q <= '0;
          up_q  <= 1'b1;
        end else if (up_q) begin
          if (cnt_q >= top_act_q) begin
            up_q  <= 1'b0;
            cnt_q <= cnt_q - ONE;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            up_q  <= 1'b1;
            cnt_q <= cnt_q + ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
      end else begin
        up_q  <= 1'b1;
        cnt_q <= (cnt_q >= top_act_q) ? '0 : cnt_q + ONE;
      end
    end
  end

endmodule

// File: rtl/wt_wave.sv
module wt_wave
  import wave_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  cnt_mode_e tmode,
  input  pin_mode_e pmode,
  input  logic      hit,
  input  logic      wrap,
  input  logic      up,
  input  logic      cmp_zero,
  input  logic      cmp_full,
  output logic      pin_q
);
  logic lvl_q;
  logic lvl_n;
  logic inv;
  logic tri_m;
  logic ramp_m;

  assign inv    = (pmode == PIN_SET);
  assign tri_m  = (tmode == CNT_TRIANGLE);
  assign ramp_m = (tmode == CNT_RAMP);

  // Non-inverted PWM level for the next tick.
  always_comb begin
    lvl_n = lvl_q;
    if (ramp_m) begin
      if (wrap)     lvl_n = 1'b1;
      else if (hit) lvl_n = 1'b0;
    end else if (tri_m) begin
      if (cmp_zero)      lvl_n = 1'b0;
      else if (cmp_full) lvl_n = 1'b1;
      else if (hit)      lvl_n = !up;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (pmode == PIN_OFF) begin
      pin_q <= 1'b0;
    end else if (tick) begin
      if (pmode == PIN_TOGGLE) begin
        if (hit) pin_q <= !pin_q;
      end else if (ramp_m || tri_m) begin
        lvl_q <= lvl_n;
        pin_q <= lvl_n ^ inv;
      end else if (hit) begin
        pin_q <= inv;
      end
    end
  end

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       clk_sel_i,
  input  logic [CNT_W-1:0] top_val_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic [1:0]       a_pin_mode_i,
  input  logic [1:0]       b_pin_mode_i,
  output logic             wave_a_o,
  output logic             wave_b_o,
  output logic             top_hit_o
);
  cnt_mode_e        tmode;
  logic             tick_w;
  logic [CNT_W-1:0] cnt_w;
  logic             up_w;
  logic [CNT_W-1:0] top_act_w;
  logic [CNT_W-1:0] cmp_act_w;
  logic             hit_top_w;
  logic             hit_cmp_w;

  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] ch_zero;
  logic [NUM_CH-1:0] ch_full;
  logic [NUM_CH-1:0] ch_pin;
  pin_mode_e         ch_mode [NUM_CH];

  assign tmode = cnt_mode_e'(mode_i);

  wt_prescale u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (clk_sel_i),
    .tick (tick_w)
  );

  wt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .mode      (tmode),
    .top_in    (top_val_i),
    .cmp_in    (cmp_val_i),
    .cnt_q     (cnt_w),
    .up_q      (up_w),
    .top_act_q (top_act_w),
    .cmp_act_q (cmp_act_w),
    .hit_top   (hit_top_w),
    .hit_cmp   (hit_cmp_w)
  );

  // Channel 0 compares against the top value, channel 1 against the duty value.
  always_comb begin
    ch_hit[0]  = hit_top_w;
    ch_zero[0] = (top_act_w == '0);
    ch_full[0] = 1'b1;
    ch_mode[0] = pin_mode_e'(a_pin_mode_i);
    ch_hit[1]  = hit_cmp_w;
    ch_zero[1] = (cmp_act_w == '0);
    ch_full[1] = (cmp_act_w >= top_act_w);
    ch_mode[1] = pin_mode_e'(b_pin_mode_i);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wt_wave u_wave (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_w),
      .tmode    (tmode),
      .pmode    (ch_mode[ch]),
      .hit      (ch_hit[ch]),
      .wrap     (hit_top_w),
      .up       (up_w),
      .cmp_zero (ch_zero[ch]),
      .cmp_full (ch_full[ch]),
      .pin_q    (ch_pin[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) top_hit_o <= 1'b0;
    else     top_hit_o <= hit_top_w;
  end

  assign wave_a_o = ch_pin[0];
  assign wave_b_o = ch_pin[1];

endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic [2:0]       clk_sel_i,
  input logic [1:0]       a_pin_mode_i,
  input logic [1:0]       b_pin_mode_i,
  input logic             wave_a_o,
  input logic             wave_b_o,
  input logic             top_hit_o,
  input logic [CNT_W-1:0] cnt,
  input logic             tick
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!wave_a_o && !wave_b_o && !top_hit_o && cnt == '0));

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  assert_stopped_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clk_sel_i) == 3'd0) |-> !top_hit_o);

  assert_clear_after_top_R3: assert property (@(posedge clk) disable iff (rst)
    (top_hit_o && $past(mode_i) == 2'd0) |-> (cnt == '0));

  assert_toggle_on_top_R4: assert property (@(posedge clk) disable iff (rst)
    (top_hit_o && $past(a_pin_mode_i) == 2'd1) |-> (wave_a_o != $past(wave_a_o)));

  assert_off_pin_low_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(b_pin_mode_i) == 2'd0) |-> !wave_b_o);

endmodule

bind wave_timer wave_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_i       (mode_i),
  .clk_sel_i    (clk_sel_i),
  .a_pin_mode_i (a_pin_mode_i),
  .b_pin_mode_i (b_pin_mode_i),
  .wave_a_o     (wave_a_o),
  .wave_b_o     (wave_b_o),
  .top_hit_o    (top_hit_o),
  .cnt          (cnt_w),
  .tick         (tick_w)
);

// File: tb/wave_timer_tb_top.sv
module wave_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int LIM        = 20000;
  localparam int NVEC       = 9;

  typedef struct packed {
    logic [1:0] md;
    logic [2:0] sel;
    logic [7:0] ta;
    logic [7:0] tb;
    logic [1:0] pa;
    logic [1:0] pb;
    int         a_hi;
    int         a_per;
    int         b_hi;
    int         b_per;
  } vec_t;

  // mode, divider, top, duty, pinA, pinB, A high, A period, B high, B period
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 3'd1, 8'd5,  8'd2, 2'd1, 2'd2,    6,   12,    3,    6},
    '{2'd1, 3'd2, 8'd9,  8'd6, 2'd1, 2'd3,   80,  160,   24,   80},
    '{2'd2, 3'd1, 8'd4,  8'd2, 2'd1, 2'd2,    8,   16,    4,    8},
    '{2'd2, 3'd2, 8'd10, 8'd3, 2'd1, 2'd2,  160,  320,   48,  160},
    '{2'd0, 3'd1, 8'd7,  8'd3, 2'd1, 2'd1,    8,   16,    8,   16},
    '{2'd0, 3'd3, 8'd3,  8'd1, 2'd1, 2'd1,  256,  512,  256,  512},
    '{2'd1, 3'd4, 8'd2,  8'd0, 2'd1, 2'd2,  768, 1536,  256,  768},
    '{2'd1, 3'd5, 8'd1,  8'd0, 2'd1, 2'd2, 2048, 4096, 1024, 2048},
    '{2'd2, 3'd1, 8'd6,  8'd2, 2'd1, 2'd3,   12,   24,    8,   12}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic [2:0] clk_sel_i = 3'd1;
  logic [7:0] top_val_i = 8'd0;
  logic [7:0] cmp_val_i = 8'd0;
  logic [1:0] a_pin_mode_i = 2'd0;
  logic [1:0] b_pin_mode_i = 2'd0;
  logic       wave_a_o;
  logic       wave_b_o;
  logic       top_hit_o;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer dut_i (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .clk_sel_i    (clk_sel_i),
    .top_val_i    (top_val_i),
    .cmp_val_i    (cmp_val_i),
    .a_pin_mode_i (a_pin_mode_i),
    .b_pin_mode_i (b_pin_mode_i),
    .wave_a_o     (wave_a_o),
    .wave_b_o     (wave_b_o),
    .top_hit_o    (top_hit_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  function automatic logic pin(input bit b);
    return b ? wave_b_o : wave_a_o;
  endfunction

  task automatic setup(input logic [1:0] md, input logic [2:0] sel, input logic [7:0] ta,
                       input logic [7:0] tb, input logic [1:0] pa, input logic [1:0] pb);
    @(negedge clk);
    mode_i = md; clk_sel_i = sel; top_val_i = ta; cmp_val_i = tb;
    a_pin_mode_i = pa; b_pin_mode_i = pb;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input bit b, output int hi, output int per);
    int lo = 0;
    int guard = 0;
    hi = 0;
    while (pin(b) == 1'b1 && guard < LIM) begin @(negedge clk); guard++; end
    while (pin(b) == 1'b0 && guard < LIM) begin @(negedge clk); guard++; end
    while (pin(b) == 1'b1 && guard < LIM) begin @(negedge clk); hi++; guard++; end
    while (pin(b) == 1'b0 && guard < LIM) begin @(negedge clk); lo++; guard++; end
    per = hi + lo;
  endtask

  task automatic high_count(input bit b, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin(b)) cnt++;
    end
  endtask

  task automatic hit_shape(output int width, output int gap);
    int guard = 0;
    int lo = 0;
    width = 0;
    while (top_hit_o == 1'b1 && guard < LIM) begin @(negedge clk); guard++; end
    while (top_hit_o == 1'b0 && guard < LIM) begin @(negedge clk); guard++; end
    while (top_hit_o == 1'b1 && guard < LIM) begin @(negedge clk); width++; guard++; end
    while (top_hit_o == 1'b0 && guard < LIM) begin @(negedge clk); lo++; guard++; end
    gap = width + lo;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int hi, per, cnt, w, g, c;

    // R1: reset state after activity
    setup(2'd0, 3'd1, 8'd3, 8'd1, 2'd1, 2'd1);
    repeat (23) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "wave_a after reset", int'(wave_a_o), 0);
    check("R1", "wave_b after reset", int'(wave_b_o), 0);
    check("R1", "top_hit after reset", int'(top_hit_o), 0);
    rst = 1'b0;

    // Table walk: R2 dividers, R4 toggle, R5 ramp, R6 inverting, R7 triangle, R3 clear-on-match
    for (int v = 0; v < NVEC; v++) begin
      setup(VECS[v].md, VECS[v].sel, VECS[v].ta, VECS[v].tb, VECS[v].pa, VECS[v].pb);
      repeat (VECS[v].a_per + 20) @(negedge clk);
      measure(1'b1, hi, per);
      check("R2/R5/R6/R7", $sformatf("vec%0d B high", v), hi, VECS[v].b_hi);
      check("R2/R5/R6/R7", $sformatf("vec%0d B period", v), per, VECS[v].b_per);
      measure(1'b0, hi, per);
      check("R4", $sformatf("vec%0d A high", v), hi, VECS[v].a_hi);
      check("R4", $sformatf("vec%0d A period", v), per, VECS[v].a_per);
    end

    // R2: stopped divider codes
    setup(2'd1, 3'd0, 8'd3, 8'd1, 2'd1, 2'd2);
    high_count(1'b0, 300, cnt);
    check("R2", "code0 wave_a highs", cnt, 0);
    setup(2'd1, 3'd6, 8'd3, 8'd1, 2'd1, 2'd2);
    c = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (top_hit_o || wave_b_o) c++;
    end
    check("R2", "code6 activity", c, 0);

    // R3: clear-on-match pulse spacing
    setup(2'd0, 3'd1, 8'd4, 8'd0, 2'd0, 2'd0);
    repeat (10) @(negedge clk);
    hit_shape(w, g);
    check("R3", "top_hit spacing T=4", g, 5);

    // R12: pulse width with divider
    setup(2'd1, 3'd2, 8'd2, 8'd0, 2'd0, 2'd0);
    repeat (40) @(negedge clk);
    hit_shape(w, g);
    check("R12", "top_hit width div8", w, 1);
    check("R12", "top_hit spacing div8", g, 24);

    // R5: duty at or above top holds the ramp output high
    setup(2'd1, 3'd1, 8'd5, 8'd5, 2'd0, 2'd2);
    repeat (20) @(negedge clk);
    high_count(1'b1, 60, cnt);
    check("R5", "ramp D=T highs", cnt, 60);

    // R8: triangle extremes
    setup(2'd2, 3'd1, 8'd5, 8'd0, 2'd0, 2'd2);
    repeat (20) @(negedge clk);
    high_count(1'b1, 60, cnt);
    check("R8", "triangle D=0 highs", cnt, 0);
    setup(2'd2, 3'd1, 8'd5, 8'd7, 2'd0, 2'd2);
    repeat (20) @(negedge clk);
    high_count(1'b1, 60, cnt);
    check("R8", "triangle D>T highs", cnt, 60);

    // R9: clear-on-match mode with set and clear pin codes
    setup(2'd0, 3'd1, 8'd3, 8'd1, 2'd3, 2'd2);
    repeat (20) @(negedge clk);
    high_count(1'b0, 50, cnt);
    check("R9", "set code wave_a highs", cnt, 50);
    high_count(1'b1, 50, cnt);
    check("R9", "clear code wave_b highs", cnt, 0);

    // R10: off code keeps pins low
    setup(2'd1, 3'd1, 8'd5, 8'd2, 2'd0, 2'd0);
    c = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wave_a_o || wave_b_o) c++;
    end
    check("R10", "off code highs", c, 0);

    // R11: mid-cycle top change waits for the current cycle to finish
    setup(2'd1, 3'd1, 8'd9, 8'd0, 2'd0, 2'd0);
    repeat (40) @(negedge clk);
    c = 0;
    while (!top_hit_o && c < LIM) begin @(negedge clk); c++; end
    top_val_i = 8'd3;
    c = 0;
    do begin @(negedge clk); c++; end while (!top_hit_o && c < LIM);
    check("R11", "gap after write", c, 10);
    c = 0;
    do begin @(negedge clk); c++; end while (!top_hit_o && c < LIM);
    check("R11", "gap with new top", c, 4);

    done = 1'b1;
    summary();
  end

endmodule